// File: doc/BRIEF.md
# Dual-Port Fully Associative Address Translation Buffer

This block holds a small set of page translations and looks up two virtual addresses at once. Each lookup compares the virtual page number and the region identifier against every stored entry in parallel. It returns the physical address, a hit flag, an error flag for conflicting entries, and a one-hot vector that names the matching entry. A downstream tag array that stores entry pointers instead of physical tags can use that vector directly, so the fast path needs no read of the stored physical page.

A single write port installs an entry at a chosen index, invalidates one entry, or flushes every entry. Pages are a fixed 4 KB, so the low twelve address bits pass straight through. All lookup results are registered: they appear on the clock cycle after the address is presented. A write takes effect on the following cycle, so a lookup issued in the same cycle as a write sees the old contents.

Top module: `xlb_top`

## Requirements
- R1: The buffer has 32 entries, selected by a 5-bit index. After reset every entry is invalid, and all lookup outputs (match vector, hit, error, physical address) read zero.
- R2: A lookup matches entry i when entry i is valid, its stored page number equals address bits [63:12], and its stored region equals the lookup region. Bit i of that port's match vector is then set, and hit is 1. Results are registered and appear one cycle after the lookup is presented.
- R3: On a hit, the physical address is {stored 38-bit page, address bits [11:0]} (50 bits). On a miss, the match vector, hit and physical address are all zero.
- R4: With write enable and operation code 2'b01 (install), the page, region and physical page are written at the index and the entry becomes valid. Lookups presented from the next cycle on see the new entry. A lookup presented in the same cycle as the write sees the old contents.
- R5: Operation code 2'b10 (invalidate) clears the valid bit of the indexed entry only. Other entries keep matching.
- R6: Operation code 2'b11 (flush) clears the valid bit of every entry.
- R7: The two lookup ports work independently in the same cycle, each with its own address, region and outputs.
- R8: When more than one entry matches, the port's error flag is 1, hit is 1, the match vector shows every matching entry, and the physical page is the bitwise OR of the matching entries' pages. The error flag is 0 whenever at most one entry matches.
- R9: A write with write enable low, or with operation code 2'b00, changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write port enable |
| wr_op | input | 2 | 00 none, 01 install, 10 invalidate, 11 flush |
| wr_idx | input | 5 | Entry index for install or invalidate |
| wr_vpn | input | 52 | Virtual page number to install |
| wr_rid | input | 24 | Region identifier to install |
| wr_ppn | input | 38 | Physical page number to install |
| lk0_va | input | 64 | Port 0 virtual address |
| lk0_rid | input | 24 | Port 0 region identifier |
| lk1_va | input | 64 | Port 1 virtual address |
| lk1_rid | input | 24 | Port 1 region identifier |
| lk0_match | output | 32 | Port 0 per-entry match vector |
| lk0_hit | output | 1 | Port 0 hit |
| lk0_err | output | 1 | Port 0 multiple-match error |
| lk0_pa | output | 50 | Port 0 physical address |
| lk1_match | output | 32 | Port 1 per-entry match vector |
| lk1_hit | output | 1 | Port 1 hit |
| lk1_err | output | 1 | Port 1 multiple-match error |
| lk1_pa | output | 50 | Port 1 physical address |

## Verification
The bench builds the block with its default parameters: 32 entries, a 64-bit address, 24-bit regions and 38-bit physical pages, with the page offset fixed at 12 bits. Random installs draw page numbers and regions from small pools. This makes duplicate keys, and so multi-hot results with OR-ed physical pages, common. Flushes and invalidates are mixed into the random traffic. Same-cycle write and lookup ordering is reached on both ports together.

// File: rtl/xlb_pkg.sv
package xlb_pkg;
   typedef enum logic [1:0] {
      WR_NOP     = 2'b00,
      WR_INSTALL = 2'b01,
      WR_INVAL   = 2'b10,
      WR_FLUSH   = 2'b11
   } wr_op_e;

   localparam int NUM_PORTS = 2;
endpackage

// File: rtl/xlb_store.sv
module xlb_store
   import xlb_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int VPN_W   = 52,
   parameter int RID_W   = 24,
   parameter int PPN_W   = 38,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_op,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [RID_W-1:0] wr_rid,
   input  logic [PPN_W-1:0] wr_ppn,
   output logic [ENTRIES-1:0] valid_q,
   output logic [VPN_W-1:0] vpn_q [ENTRIES],
   output logic [RID_W-1:0] rid_q [ENTRIES],
   output logic [PPN_W-1:0] ppn_q [ENTRIES]
);
   wr_op_e op;
   assign op = wr_op_e'(wr_op);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic sel;
      assign sel = (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[e] <= 1'b0;
         end else if (wr_en) begin
            unique case (op)
               WR_INSTALL: if (sel) valid_q[e] <= 1'b1;
               WR_INVAL:   if (sel) valid_q[e] <= 1'b0;
               WR_FLUSH:   valid_q[e] <= 1'b0;
               default:    ;
            endcase
         end
      end

      always_ff @(posedge clk) begin
         if (wr_en && op == WR_INSTALL && sel) begin
            vpn_q[e] <= wr_vpn;
            rid_q[e] <= wr_rid;
            ppn_q[e] <= wr_ppn;
         end
      end
   end

   AST_INSTALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_op == WR_INSTALL && 32'(wr_idx) < ENTRIES) |=> valid_q[$past(wr_idx)]); // R4
   AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_op == WR_INVAL && 32'(wr_idx) < ENTRIES) |=> !valid_q[$past(wr_idx)]); // R5
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_op == WR_FLUSH) |=> valid_q == '0); // R6
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || wr_op == WR_NOP) |=> $stable(valid_q)); // R9
endmodule

// File: rtl/xlb_match.sv
module xlb_match #(
   parameter int ENTRIES = 32,
   parameter int VPN_W   = 52,
   parameter int RID_W   = 24
) (
   input  logic [ENTRIES-1:0] valid_q,
   input  logic [VPN_W-1:0]   vpn_q [ENTRIES],
   input  logic [RID_W-1:0]   rid_q [ENTRIES],
   input  logic [VPN_W-1:0]   look_vpn,
   input  logic [RID_W-1:0]   look_rid,
   output logic [ENTRIES-1:0] match
);
   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign match[e] = valid_q[e] && (vpn_q[e] == look_vpn) && (rid_q[e] == look_rid);
   end
endmodule

// File: rtl/xlb_select.sv
module xlb_select #(
   parameter int ENTRIES = 32,
   parameter int PPN_W   = 38
) (
   input  logic [ENTRIES-1:0] match,
   input  logic [PPN_W-1:0]   ppn_q [ENTRIES],
   output logic [PPN_W-1:0]   ppn_sel,
   output logic               any,
   output logic               multi
);
   always_comb begin
      logic seen;
      ppn_sel = '0;
      seen    = 1'b0;
      multi   = 1'b0;
      for (int e = 0; e < ENTRIES; e++) begin
         ppn_sel = ppn_sel | (ppn_q[e] & {PPN_W{match[e]}});
         multi   = multi | (seen & match[e]);
         seen    = seen | match[e];
      end
      any = seen;
   end
endmodule

// File: rtl/xlb_top.sv
module xlb_top
   import xlb_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int VA_W    = 64,
   parameter int OFS_W   = 12,
   parameter int RID_W   = 24,
   parameter int PPN_W   = 38,
   localparam int VPN_W  = VA_W - OFS_W,
   localparam int PA_W   = PPN_W + OFS_W,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_op,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [VPN_W-1:0]   wr_vpn,
   input  logic [RID_W-1:0]   wr_rid,
   input  logic [PPN_W-1:0]   wr_ppn,
   input  logic [VA_W-1:0]    lk0_va,
   input  logic [RID_W-1:0]   lk0_rid,
   input  logic [VA_W-1:0]    lk1_va,
   input  logic [RID_W-1:0]   lk1_rid,
   output logic [ENTRIES-1:0] lk0_match,
   output logic               lk0_hit,
   output logic               lk0_err,
   output logic [PA_W-1:0]    lk0_pa,
   output logic [ENTRIES-1:0] lk1_match,
   output logic               lk1_hit,
   output logic               lk1_err,
   output logic [PA_W-1:0]    lk1_pa
);
   if (ENTRIES < 2) begin : g_bad_entries
      $error("xlb_top: ENTRIES must be at least 2");
   end
   if (OFS_W < 1 || VA_W <= OFS_W) begin : g_bad_offset
      $error("xlb_top: VA_W must exceed OFS_W, OFS_W must be positive");
   end
   if (PPN_W < 1 || RID_W < 1) begin : g_bad_fields
      $error("xlb_top: PPN_W and RID_W must be positive");
   end

   logic [ENTRIES-1:0] valid_q;
   logic [VPN_W-1:0]   vpn_q [ENTRIES];
   logic [RID_W-1:0]   rid_q [ENTRIES];
   logic [PPN_W-1:0]   ppn_q [ENTRIES];

   xlb_store #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .RID_W(RID_W), .PPN_W(PPN_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op), .wr_idx(wr_idx),
      .wr_vpn(wr_vpn), .wr_rid(wr_rid), .wr_ppn(wr_ppn),
      .valid_q(valid_q), .vpn_q(vpn_q), .rid_q(rid_q), .ppn_q(ppn_q)
   );

   logic [VA_W-1:0]    lk_va    [NUM_PORTS];
   logic [RID_W-1:0]   lk_rid   [NUM_PORTS];
   logic [ENTRIES-1:0] match_q  [NUM_PORTS];
   logic               hit_q    [NUM_PORTS];
   logic               err_q    [NUM_PORTS];
   logic [PA_W-1:0]    pa_q     [NUM_PORTS];

   assign lk_va[0]  = lk0_va;
   assign lk_va[1]  = lk1_va;
   assign lk_rid[0] = lk0_rid;
   assign lk_rid[1] = lk1_rid;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic [ENTRIES-1:0] match;
      logic [PPN_W-1:0]   ppn_sel;
      logic               any;
      logic               multi;

      xlb_match #(
         .ENTRIES(ENTRIES), .VPN_W(VPN_W), .RID_W(RID_W)
      ) u_match (
         .valid_q(valid_q), .vpn_q(vpn_q), .rid_q(rid_q),
         .look_vpn(lk_va[p][VA_W-1:OFS_W]), .look_rid(lk_rid[p]),
         .match(match)
      );

      xlb_select #(
         .ENTRIES(ENTRIES), .PPN_W(PPN_W)
      ) u_select (
         .match(match), .ppn_q(ppn_q),
         .ppn_sel(ppn_sel), .any(any), .multi(multi)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            match_q[p] <= '0;
            hit_q[p]   <= 1'b0;
            err_q[p]   <= 1'b0;
            pa_q[p]    <= '0;
         end else begin
            match_q[p] <= match;
            hit_q[p]   <= any;
            err_q[p]   <= multi;
            pa_q[p]    <= {ppn_sel, lk_va[p][OFS_W-1:0] & {OFS_W{any}}};
         end
      end

      AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         !hit_q[p] |-> (pa_q[p] == '0 && match_q[p] == '0)); // R3
      AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
         hit_q[p] |-> pa_q[p][OFS_W-1:0] == $past(lk_va[p][OFS_W-1:0])); // R3
      AST_ONEHOT_OK: assert property (@(posedge clk) disable iff (!rst_n)
         !err_q[p] |-> $onehot0(match_q[p])); // R8
      AST_ERR_HAS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
         err_q[p] |-> (hit_q[p] && $countones(match_q[p]) > 1)); // R8
   end

   assign lk0_match = match_q[0];
   assign lk0_hit   = hit_q[0];
   assign lk0_err   = err_q[0];
   assign lk0_pa    = pa_q[0];
   assign lk1_match = match_q[1];
   assign lk1_hit   = hit_q[1];
   assign lk1_err   = err_q[1];
   assign lk1_pa    = pa_q[1];
endmodule

// File: tb/xlb_top_tb.sv
module xlb_top_tb;
   localparam int N = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_op = 2'b00;
   logic [4:0]  wr_idx = '0;
   logic [51:0] wr_vpn = '0;
   logic [23:0] wr_rid = '0;
   logic [37:0] wr_ppn = '0;
   logic [63:0] lk0_va = '0, lk1_va = '0;
   logic [23:0] lk0_rid = '0, lk1_rid = '0;
   logic [31:0] lk0_match, lk1_match;
   logic        lk0_hit, lk1_hit, lk0_err, lk1_err;
   logic [49:0] lk0_pa, lk1_pa;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 0;

   always #4 clk = ~clk;

   xlb_top u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op), .wr_idx(wr_idx),
      .wr_vpn(wr_vpn), .wr_rid(wr_rid), .wr_ppn(wr_ppn),
      .lk0_va(lk0_va), .lk0_rid(lk0_rid), .lk1_va(lk1_va), .lk1_rid(lk1_rid),
      .lk0_match(lk0_match), .lk0_hit(lk0_hit), .lk0_err(lk0_err), .lk0_pa(lk0_pa),
      .lk1_match(lk1_match), .lk1_hit(lk1_hit), .lk1_err(lk1_err), .lk1_pa(lk1_pa)
   );

   logic        m_val [N];
   logic [51:0] m_vpn [N];
   logic [23:0] m_rid [N];
   logic [37:0] m_ppn [N];

   typedef struct packed {
      logic [31:0] match;
      logic        hit;
      logic        err;
      logic [49:0] pa;
   } res_t;

   function automatic res_t expect_res(logic [63:0] va, logic [23:0] rid);
      res_t r;
      logic [37:0] acc;
      int cnt;
      r = '0; acc = '0; cnt = 0;
      for (int e = 0; e < N; e++) begin
         if (m_val[e] && m_vpn[e] == va[63:12] && m_rid[e] == rid) begin
            r.match[e] = 1'b1;
            acc = acc | m_ppn[e];
            cnt++;
         end
      end
      r.hit = (cnt > 0);
      r.err = (cnt > 1);
      r.pa  = r.hit ? {acc, va[11:0]} : 50'd0;
      return r;
   endfunction

   task automatic compare(string tag, int port, res_t act, res_t exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s port%0d: match=%h hit=%b err=%b pa=%h expected match=%h hit=%b err=%b pa=%h",
                  tag, port, act.match, act.hit, act.err, act.pa,
                  exp.match, exp.hit, exp.err, exp.pa);
      end
   endtask

   // One cycle: inputs already driven at a negedge; check outputs at the next negedge.
   task automatic step(string tag);
      res_t e0, e1, a0, a1;
      e0 = expect_res(lk0_va, lk0_rid);
      e1 = expect_res(lk1_va, lk1_rid);
      @(posedge clk);
      #1;
      if (wr_en) begin
         case (wr_op)
            2'b01: begin
               m_val[wr_idx] = 1'b1; m_vpn[wr_idx] = wr_vpn;
               m_rid[wr_idx] = wr_rid; m_ppn[wr_idx] = wr_ppn;
            end
            2'b10: m_val[wr_idx] = 1'b0;
            2'b11: for (int e = 0; e < N; e++) m_val[e] = 1'b0;
            default: ;
         endcase
      end
      @(negedge clk);
      a0 = {lk0_match, lk0_hit, lk0_err, lk0_pa};
      a1 = {lk1_match, lk1_hit, lk1_err, lk1_pa};
      compare(tag, 0, a0, e0);
      compare(tag, 1, a1, e1);
   endtask

   task automatic set_wr(logic en, logic [1:0] op, int idx, logic [51:0] vpn,
                         logic [23:0] rid, logic [37:0] ppn);
      wr_en = en; wr_op = op; wr_idx = 5'(idx);
      wr_vpn = vpn; wr_rid = rid; wr_ppn = ppn;
   endtask

   task automatic set_lk(logic [51:0] v0, logic [11:0] o0, logic [23:0] r0,
                         logic [51:0] v1, logic [11:0] o1, logic [23:0] r1);
      lk0_va = {v0, o0}; lk0_rid = r0;
      lk1_va = {v1, o1}; lk1_rid = r1;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1;
         tests++; fails++;
         $display("FAIL watchdog: cycles=%0d expected finish before 100000", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   localparam logic [51:0] KA = 52'hA_BCDE_F012_3456;
   localparam logic [51:0] KB = 52'h1_1111_2222_3333;
   localparam logic [23:0] RA = 24'h00_0A5A;
   localparam logic [23:0] RB = 24'h00_0B5B;

   initial begin
      int seed;
      seed = $urandom(32'h5EED_1234);
      for (int e = 0; e < N; e++) begin
         m_val[e] = 1'b0; m_vpn[e] = '0; m_rid[e] = '0; m_ppn[e] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state, everything zero
      compare("R1 reset", 0, {lk0_match, lk0_hit, lk0_err, lk0_pa}, '0);
      compare("R1 reset", 1, {lk1_match, lk1_hit, lk1_err, lk1_pa}, '0);
      set_lk(KA, 12'h123, RA, KA, 12'h456, RB);
      step("R1 empty lookup");

      // R4: install at 5 with same-cycle lookup -> old contents (miss)
      set_wr(1, 2'b01, 5, KA, RA, 38'h2A_1234_5678);
      set_lk(KA, 12'h010, RA, KA, 12'h020, RA);
      step("R4 same-cycle old");
      set_wr(0, 2'b00, 0, '0, '0, '0);
      // R2: next cycle hits; port1 wrong region misses
      set_lk(KA, 12'h010, RA, KA, 12'h020, RB);
      step("R2 hit and region miss");
      // R3: offset pass-through on both ports
      set_lk(KA, 12'hFFF, RA, KA, 12'hABC, RA);
      step("R3 offset");

      // R7: independent ports, second entry
      set_wr(1, 2'b01, 7, KB, RB, 38'h01_0F0F_0F0F);
      step("R7 install second");
      set_wr(0, 2'b00, 0, '0, '0, '0);
      set_lk(KB, 12'h001, RB, KA, 12'h002, RA);
      step("R7 ports independent");

      // R9: disabled write and NOP write change nothing
      set_wr(0, 2'b01, 5, KB, RA, 38'h3);
      step("R9 write disabled");
      set_wr(1, 2'b00, 7, KA, RB, 38'h4);
      step("R9 nop op");
      set_wr(0, 2'b00, 0, '0, '0, '0);
      set_lk(KB, 12'h0, RA, KA, 12'h0, RB);
      step("R9 no new key");
      set_lk(KA, 12'h5, RA, KB, 12'h6, RB);
      step("R9 old keys kept");

      // R8: duplicate key at 9 and 10 -> multi-hot, OR of pages
      set_wr(1, 2'b01, 9, KB, RA, 38'h00_0000_00F0);
      step("R8 dup a");
      set_wr(1, 2'b01, 10, KB, RA, 38'h10_0000_000F);
      step("R8 dup b");
      set_wr(0, 2'b00, 0, '0, '0, '0);
      set_lk(KB, 12'h777, RA, KB, 12'h888, RA);
      step("R8 multi hit");

      // R5: invalidate 5 only
      set_wr(1, 2'b10, 5, '0, '0, '0);
      set_lk(KA, 12'h1, RA, KB, 12'h2, RB);
      step("R5 invalidate same-cycle");
      set_wr(0, 2'b00, 0, '0, '0, '0);
      step("R5 invalidated miss, other hits");

      // R6: flush
      set_wr(1, 2'b11, 0, '0, '0, '0);
      step("R6 flush issue");
      set_wr(0, 2'b00, 0, '0, '0, '0);
      set_lk(KB, 12'h3, RB, KB, 12'h4, RA);
      step("R6 after flush");

      // Random traffic
      for (int i = 0; i < 4000; i++) begin
         int r;
         logic [51:0] v0, v1;
         logic [23:0] q0, q1;
         r = int'($urandom % 100);
         if (r < 45)
            set_wr(1, 2'b01, int'($urandom % 32), 52'h1000 + 52'($urandom % 24),
                   24'($urandom % 3), {6'($urandom), 32'($urandom)});
         else if (r < 55)
            set_wr(1, 2'b10, int'($urandom % 32), '0, '0, '0);
         else if (r < 57)
            set_wr(1, 2'b11, 0, '0, '0, '0);
         else if (r < 62)
            set_wr(1, 2'b00, int'($urandom % 32), 52'h1000, 24'd0, 38'h1);
         else
            set_wr(0, 2'($urandom), int'($urandom % 32), 52'h1001, 24'd1, 38'h2);
         v0 = ($urandom % 5 == 0) ? {$urandom, 20'($urandom)} : 52'h1000 + 52'($urandom % 24);
         v1 = ($urandom % 5 == 0) ? {$urandom, 20'($urandom)} : 52'h1000 + 52'($urandom % 24);
         q0 = 24'($urandom % 3);
         q1 = 24'($urandom % 3);
         set_lk(v0, 12'($urandom), q0, v1, 12'($urandom), q1);
         step("R7 random (R2 R4 R5 R6 R8 R9)");
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule